// File: doc/BRIEF.md
# Station Address Boot Loader

This block fills the two station-address registers of an Ethernet port from a serial configuration memory once reset is released. It issues byte reads through a request/acknowledge port. The bit-level serial controller sits behind that port and may take any number of cycles to answer each read.

The byte at offset 0 is a signature. Only the value A5h lets the load go ahead. When the signature matches, the six bytes that follow are packed little-endian. The first four go into a 32-bit low register and the last two go into a 16-bit high register. Both registers change in a single cycle.

A `done` flag marks the end of the boot sequence, whatever its outcome. A `loaded` flag shows whether the address was taken from the memory. Once `done` is set, host software may overwrite either register.

Top module: `mac_addr_loader`

## Requirements
- R1: After reset is released the block reads offset 0 first, then offsets 1, 2, 3, 4, 5 and 6 in that order, each exactly once. It never presents an offset above 6.
- R2: Only one read is outstanding at a time. `rd_req` stays high with `rd_addr` unchanged until a cycle in which `rd_ack` is high. `rd_data` is taken in that cycle, so any latency from the memory is tolerated.
- R3: A signature byte equal to A5h leads to `loaded` = 1 when the load completes. Any other value ends the sequence after that single read: `done` = 1, `loaded` = 0, and both registers stay at their reset value of zero.
- R4: `addr_lo` bits 7:0, 15:8, 23:16 and 31:24 hold the bytes from offsets 1, 2, 3 and 4 respectively.
- R5: `addr_hi` bits 7:0 hold the byte from offset 5 and bits 15:8 hold the byte from offset 6.
- R6: Both address registers keep their value while loading is in progress. They take the new address on the same clock edge on which `done` rises, which is the edge that samples the acknowledge for offset 6.
- R7: Once set, `done` stays high until the next reset, and no further read is requested after it.
- R8: With `done` high, a cycle with `host_wr_lo` high loads `host_wdata` into `addr_lo`. A cycle with `host_wr_hi` high loads `host_wdata[15:0]` into `addr_hi`. Each new value is visible after the next clock edge.
- R9: Host writes made while `done` is low have no effect on either register.
- R10: While reset is asserted, `done`, `loaded` and `rd_req` are 0, and `addr_lo` and `addr_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | output | 1 | Byte read request to the memory controller |
| rd_addr | output | 8 | Byte offset being read |
| rd_ack | input | 1 | Read complete; `rd_data` is valid this cycle |
| rd_data | input | 8 | Byte returned by the memory controller |
| host_wr_lo | input | 1 | Host write strobe for the low address register |
| host_wr_hi | input | 1 | Host write strobe for the high address register |
| host_wdata | input | 32 | Host write data |
| addr_lo | output | 32 | Station address, first four bytes |
| addr_hi | output | 16 | Station address, last two bytes |
| done | output | 1 | Boot sequence finished |
| loaded | output | 1 | Address was taken from the memory |

## Verification
Several properties are checked on every cycle:
- the request is held steady until it is acknowledged;
- offsets never run past 6;
- `done` is sticky and no request follows it;
- the registers never move before `done`;
- `loaded` implies `done`;
- host writes land after `done`.

Some behaviours can only be shown by the bench's scenarios, because they need the memory's contents in mind:
- the offsets are read in order, each once;
- the bytes are packed into the right bit positions;
- a bad signature stops the reads after offset 0;
- early host writes are dropped.

These scenarios run at several latencies.

// File: rtl/mal_pkg.sv
package mal_pkg;
   typedef enum logic [1:0] {
      LS_IDLE = 2'd0,
      LS_READ = 2'd1,
      LS_FIN  = 2'd2
   } ld_state_e;

   localparam int BYTE_W     = 8;
   localparam int SIG_OFFSET = 0;
endpackage

// File: rtl/mal_seq.sv
module mal_seq
   import mal_pkg::*;
#(
   parameter int               EE_AW    = 8,
   parameter int               NBYTES   = 6,
   parameter logic [BYTE_W-1:0] SIG_BYTE = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              rd_req,
   output logic [EE_AW-1:0]  rd_addr,
   input  logic              rd_ack,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              take,
   output logic              commit,
   output logic              done,
   output logic              loaded
);
   localparam logic [EE_AW-1:0] LAST_OFS = EE_AW'(NBYTES);
   localparam logic [EE_AW-1:0] SIG_OFS  = EE_AW'(SIG_OFFSET);

   ld_state_e        state;
   logic [EE_AW-1:0] ofs;
   logic             acked;

   assign acked   = (state == LS_READ) && rd_ack;
   assign rd_req  = (state == LS_READ);
   assign rd_addr = ofs;
   assign take    = acked && (ofs != SIG_OFS);
   assign commit  = acked && (ofs == LAST_OFS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= LS_IDLE;
         ofs    <= SIG_OFS;
         done   <= 1'b0;
         loaded <= 1'b0;
      end else begin
         case (state)
            LS_IDLE: state <= LS_READ;
            LS_READ: begin
               if (rd_ack) begin
                  if ((ofs == SIG_OFS) && (rd_data != SIG_BYTE)) begin
                     state <= LS_FIN;
                     done  <= 1'b1;
                  end else if (ofs == LAST_OFS) begin
                     state  <= LS_FIN;
                     done   <= 1'b1;
                     loaded <= 1'b1;
                  end else begin
                     ofs <= ofs + EE_AW'(1);
                  end
               end
            end
            default: state <= LS_FIN;
         endcase
      end
   end
endmodule

// File: rtl/mal_pack.sv
module mal_pack
   import mal_pkg::*;
#(
   parameter int EE_AW  = 8,
   parameter int NBYTES = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     take,
   input  logic [EE_AW-1:0]         idx,
   input  logic [BYTE_W-1:0]        din,
   output logic [BYTE_W*NBYTES-1:0] image
);
   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      logic [BYTE_W-1:0] stage;
      logic              hit;

      assign hit = take && (idx == EE_AW'(i + 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   stage <= '0;
         else if (hit) stage <= din;
      end

      // The final byte arrives in the commit cycle, so it bypasses its stage.
      assign image[BYTE_W*i +: BYTE_W] = hit ? din : stage;
   end
endmodule

// File: rtl/mal_regs.sv
module mal_regs #(
   parameter int            LO_W       = 32,
   parameter int            HI_W       = 16,
   parameter logic [LO_W-1:0] LO_RST   = '0,
   parameter logic [HI_W-1:0] HI_RST   = '0,
   parameter bit            HOST_WR_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 commit,
   input  logic [LO_W+HI_W-1:0] image,
   input  logic                 done,
   input  logic                 host_wr_lo,
   input  logic                 host_wr_hi,
   input  logic [LO_W-1:0]      host_wdata,
   output logic [LO_W-1:0]      addr_lo,
   output logic [HI_W-1:0]      addr_hi
);
   logic wr_lo, wr_hi;

   if (HOST_WR_EN) begin : g_host
      assign wr_lo = done && host_wr_lo;
      assign wr_hi = done && host_wr_hi;
   end else begin : g_nohost
      logic unused_host;
      assign unused_host = ^{done, host_wr_lo, host_wr_hi};
      assign wr_lo = 1'b0;
      assign wr_hi = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_lo <= LO_RST;
      else if (commit) addr_lo <= image[LO_W-1:0];
      else if (wr_lo)  addr_lo <= host_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_hi <= HI_RST;
      else if (commit) addr_hi <= image[LO_W +: HI_W];
      else if (wr_hi)  addr_hi <= host_wdata[HI_W-1:0];
   end
endmodule

// File: rtl/mac_addr_loader.sv
module mac_addr_loader
   import mal_pkg::*;
#(
   parameter int                    EE_AW      = 8,
   parameter int                    LO_BYTES   = 4,
   parameter int                    HI_BYTES   = 2,
   parameter logic [BYTE_W-1:0]      SIG_BYTE   = 8'hA5,
   parameter logic [8*LO_BYTES-1:0] LO_RST     = '0,
   parameter logic [8*HI_BYTES-1:0] HI_RST     = '0,
   parameter bit                    HOST_WR_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   output logic                  rd_req,
   output logic [EE_AW-1:0]      rd_addr,
   input  logic                  rd_ack,
   input  logic [7:0]            rd_data,
   input  logic                  host_wr_lo,
   input  logic                  host_wr_hi,
   input  logic [8*LO_BYTES-1:0] host_wdata,
   output logic [8*LO_BYTES-1:0] addr_lo,
   output logic [8*HI_BYTES-1:0] addr_hi,
   output logic                  done,
   output logic                  loaded
);
   localparam int NBYTES = LO_BYTES + HI_BYTES;
   localparam int LO_W   = BYTE_W * LO_BYTES;
   localparam int HI_W   = BYTE_W * HI_BYTES;

   if (EE_AW < $clog2(NBYTES + 1)) begin : g_chk_aw
      $error("EE_AW too narrow for the address offsets");
   end
   if (HI_BYTES > LO_BYTES || HI_BYTES < 1) begin : g_chk_hi
      $error("HI_BYTES must be 1..LO_BYTES");
   end

   logic                   take, commit;
   logic [BYTE_W*NBYTES-1:0] image;

   mal_seq #(.EE_AW(EE_AW), .NBYTES(NBYTES), .SIG_BYTE(SIG_BYTE)) u_seq (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_ack(rd_ack), .rd_data(rd_data), .take(take), .commit(commit),
      .done(done), .loaded(loaded)
   );

   mal_pack #(.EE_AW(EE_AW), .NBYTES(NBYTES)) u_pack (
      .clk(clk), .rst_n(rst_n), .take(take), .idx(rd_addr),
      .din(rd_data), .image(image)
   );

   mal_regs #(.LO_W(LO_W), .HI_W(HI_W), .LO_RST(LO_RST), .HI_RST(HI_RST),
              .HOST_WR_EN(HOST_WR_EN)) u_regs (
      .clk(clk), .rst_n(rst_n), .commit(commit), .image(image), .done(done),
      .host_wr_lo(host_wr_lo), .host_wr_hi(host_wr_hi), .host_wdata(host_wdata),
      .addr_lo(addr_lo), .addr_hi(addr_hi)
   );
endmodule

// File: rtl/mac_addr_loader_chk.sv
module mac_addr_loader_chk #(
   parameter int EE_AW    = 8,
   parameter int LO_W     = 32,
   parameter int HI_W     = 16,
   parameter int LAST_OFS = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rd_req,
   input logic [EE_AW-1:0] rd_addr,
   input logic            rd_ack,
   input logic            host_wr_lo,
   input logic            host_wr_hi,
   input logic [LO_W-1:0] host_wdata,
   input logic [LO_W-1:0] addr_lo,
   input logic [HI_W-1:0] addr_hi,
   input logic            done,
   input logic            loaded
);
   a_r1_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_addr <= EE_AW'(LAST_OFS)));

   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

   a_r3_loaded_done: assert property (@(posedge clk) disable iff (!rst_n)
      loaded |-> done);

   a_r6_regs_still: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> (done || ($stable(addr_lo) && $stable(addr_hi))));

   a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   a_r7_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rd_req);

   a_r8_host_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (done && host_wr_lo) |=> (addr_lo == $past(host_wdata)));

   a_r8_host_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (done && host_wr_hi) |=> (addr_hi == $past(host_wdata[HI_W-1:0])));
endmodule

bind mac_addr_loader mac_addr_loader_chk #(
   .EE_AW(EE_AW), .LO_W(8*LO_BYTES), .HI_W(8*HI_BYTES), .LAST_OFS(LO_BYTES+HI_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
   .host_wr_lo(host_wr_lo), .host_wr_hi(host_wr_hi), .host_wdata(host_wdata),
   .addr_lo(addr_lo), .addr_hi(addr_hi), .done(done), .loaded(loaded)
);

// File: tb/sim_mac_addr_loader.sv
module sim_mac_addr_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_req;
   logic [7:0]  rd_addr;
   logic        rd_ack = 1'b0;
   logic [7:0]  rd_data = '0;
   logic        host_wr_lo = 1'b0;
   logic        host_wr_hi = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] addr_lo;
   logic [15:0] addr_hi;
   logic        done, loaded;

   always #4 clk = ~clk;

   mac_addr_loader u0 (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_ack(rd_ack), .rd_data(rd_data), .host_wr_lo(host_wr_lo),
      .host_wr_hi(host_wr_hi), .host_wdata(host_wdata), .addr_lo(addr_lo),
      .addr_hi(addr_hi), .done(done), .loaded(loaded)
   );

   logic [7:0] mem [0:7];
   int lat = 0;
   int wcnt = 0;
   int exp_q[$];
   int n_chk = 0;
   int n_err = 0;

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // driver side of the scoreboard: expected read offsets
   task automatic expect_reads(input int count);
      exp_q.delete();
      for (int i = 0; i < count; i++) exp_q.push_back(i);
   endtask

   // memory model and monitor: answers requests after lat cycles, pops the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            rd_ack = 1'b0;
            wcnt = 0;
         end else if (rd_ack) begin
            rd_ack = 1'b0;
         end else if (rd_req) begin
            if (wcnt < lat) begin
               wcnt++;
            end else begin
               wcnt = 0;
               rd_ack = 1'b1;
               rd_data = mem[rd_addr[2:0]];
               if (exp_q.size() == 0) begin
                  check("R7 unexpected read", {24'h0, rd_addr}, 32'hFFFF_FFFF);
               end else begin
                  check("R1 read order", {24'h0, rd_addr}, exp_q.pop_front());
               end
            end
         end
      end
   end

   task automatic do_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R10 reset done", {31'h0, done}, 32'h0);
      check("R10 reset loaded", {31'h0, loaded}, 32'h0);
      check("R10 reset req", {31'h0, rd_req}, 32'h0);
      check("R10 reset lo", addr_lo, 32'h0);
      check("R10 reset hi", {16'h0, addr_hi}, 32'h0);
      rst_n = 1'b1;
   endtask

   task automatic wait_done;
      for (int i = 0; i < 400 && !done; i++) @(negedge clk);
      check("R7 done reached", {31'h0, done}, 32'h1);
   endtask

   task automatic load_mem(input logic [7:0] b0, b1, b2, b3, b4, b5, b6);
      mem[0] = b0; mem[1] = b1; mem[2] = b2; mem[3] = b3;
      mem[4] = b4; mem[5] = b5; mem[6] = b6; mem[7] = 8'h00;
   endtask

   initial begin
      #(8 * 200000);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      // Scenario A: valid signature, zero latency
      load_mem(8'hA5, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC);
      lat = 0;
      expect_reads(7);
      do_reset();
      wait_done();
      check("R4 low packing", addr_lo, 32'h7856_3412);
      check("R5 high packing", {16'h0, addr_hi}, 32'h0000_BC9A);
      check("R3 loaded on A5", {31'h0, loaded}, 32'h1);
      repeat (10) @(negedge clk);
      check("R7 done held", {31'h0, done}, 32'h1);
      check("R7 no request", {31'h0, rd_req}, 32'h0);
      check("R1 all offsets read", exp_q.size(), 32'h0);

      // Scenario B: bad signature, latency 2
      load_mem(8'h5A, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66);
      lat = 2;
      expect_reads(1);
      do_reset();
      wait_done();
      repeat (12) @(negedge clk);
      check("R3 not loaded", {31'h0, loaded}, 32'h0);
      check("R3 lo untouched", addr_lo, 32'h0);
      check("R3 hi untouched", {16'h0, addr_hi}, 32'h0);
      check("R3 single read", exp_q.size(), 32'h0);

      // Scenario C: slow memory, early host writes, then host override
      load_mem(8'hA5, 8'h01, 8'hF2, 8'h83, 8'hC4, 8'h3D, 8'hE6);
      lat = 6;
      expect_reads(7);
      do_reset();
      for (int i = 0; i < 400 && !(rd_req && rd_addr == 8'd3); i++) @(negedge clk);
      host_wdata = 32'hDEAD_BEEF;
      host_wr_lo = 1'b1;
      host_wr_hi = 1'b1;
      @(negedge clk);
      host_wr_lo = 1'b0;
      host_wr_hi = 1'b0;
      check("R9 early write lo ignored", addr_lo, 32'h0);
      check("R9 early write hi ignored", {16'h0, addr_hi}, 32'h0);
      check("R6 still loading", {31'h0, done}, 32'h0);
      wait_done();
      check("R6 low committed", addr_lo, 32'hC483_F201);
      check("R6 high committed", {16'h0, addr_hi}, 32'h0000_E63D);
      host_wdata = 32'h1122_3344;
      host_wr_lo = 1'b1;
      @(negedge clk);
      host_wr_lo = 1'b0;
      check("R8 host lo write", addr_lo, 32'h1122_3344);
      check("R8 hi unchanged", {16'h0, addr_hi}, 32'h0000_E63D);
      host_wdata = 32'h5555_CAFE;
      host_wr_hi = 1'b1;
      @(negedge clk);
      host_wr_hi = 1'b0;
      check("R8 host hi write", {16'h0, addr_hi}, 32'h0000_CAFE);
      check("R8 loaded kept", {31'h0, loaded}, 32'h1);
      check("R1 all offsets read slow", exp_q.size(), 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule